// File: doc/BRIEF.md
# Selectable Ratio I/O Clock Divider

This block produces the I/O bus clock from an internal clock running at twice the host clock rate, so the I/O clock keeps a fixed relation to the host clock. Two selects choose the ratio. One picks the host speed (133 MHz or 100 MHz class). The other picks the I/O speed (33 MHz or 66 MHz class). The four resulting ratios to the host clock are 4, 2, 3 and 1.5. The input runs at double the host rate, so every ratio becomes a whole number of input cycles: 8, 4, 6 and 3. The odd count of 3 gets its half-cycle high phase from an extra register clocked on the falling edge.

A new ratio waits for the current output period to end, so a select change never produces a short pulse. A one-cycle flag marks the period where the new ratio starts. A gate input stops the output at the next period boundary and restarts it with a full high phase.

Top module: `iodiv_clkgen`

## Requirements
- R1: With `host_fast`=1, the output period is 8 input cycles when `io_fast`=0 and 4 input cycles when `io_fast`=1.
- R2: With `host_fast`=0, the output period is 6 input cycles when `io_fast`=0 and 3 input cycles when `io_fast`=1.
- R3: In every mode the high and low phases are each exactly half the period. In the 3-cycle mode each phase is 1.5 input cycles, and the falling edge of `io_clk` follows a falling edge of `clk2x`.
- R4: Every rising edge of `io_clk` follows a rising edge of `clk2x`, at the start of a period.
- R5: A change of `host_fast` or `io_fast` takes effect only when the current output period has ended. Every high or low phase has the full length of either the old ratio or the new ratio. No phase of the old length follows the first phase of the new length.
- R6: `ratio_done` is high for exactly one input cycle. It rises with the rising edge of `io_clk` that starts the first period at a changed ratio. It stays low while the selects are unchanged.
- R7: When `gate_en` goes low during a period, that period completes at full length. `io_clk` then stays low and makes no rising edge while `gate_en` is low.
- R8: When `gate_en` is high again, `io_clk` rises at the first rising edge of `clk2x` that samples it high. The first high phase has full length.
- R9: `rst` is synchronous and active high. While it is held, `io_clk` is low from the end of the first input cycle in reset, and `ratio_done` is low. After release, the first rising edge of `clk2x` starts a period at the ratio given by the selects, with no `ratio_done` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk2x | input | 1 | Clock at twice the host clock rate |
| rst | input | 1 | Synchronous reset, active high |
| host_fast | input | 1 | 1 = 133 MHz-class host, 0 = 100 MHz-class host |
| io_fast | input | 1 | 1 = 66 MHz-class I/O clock, 0 = 33 MHz-class |
| gate_en | input | 1 | 1 = output runs, 0 = output stops at the next period boundary |
| io_clk | output | 1 | Divided I/O clock |
| ratio_done | output | 1 | One-cycle pulse when a changed ratio takes effect |

## Verification
The output is sampled twice per input cycle. Each of the four select settings is held steady, and the phase lengths show whether the count and the duty split are right for that ratio. Select changes are made at several points inside a high or a low phase, between ratios of different lengths. These changes separate a design that applies the new ratio at once from one that waits for the period to end, and they fix where the done pulse falls. The gate is dropped during a high phase and later raised, in an even mode and in the odd mode, to show where the output stops and restarts. A reset in the middle of the odd mode checks the falling-edge phase.

// File: rtl/iodiv_pkg.sv
`timescale 1ns/1ps
package iodiv_pkg;
  typedef enum logic [1:0] {
    RATE_HS_IOS = 2'b00,
    RATE_HS_IOF = 2'b01,
    RATE_HF_IOS = 2'b10,
    RATE_HF_IOF = 2'b11
  } io_rate_e;

  function automatic io_rate_e rate_of(input logic host_fast, input logic io_fast);
    return io_rate_e'({host_fast, io_fast});
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/iodiv_rate_sel.sv
`timescale 1ns/1ps
module iodiv_rate_sel
  import iodiv_pkg::*;
#(
  parameter int CW         = 4,
  parameter int DIV_HF_IOS = 8,
  parameter int DIV_HF_IOF = 4,
  parameter int DIV_HS_IOS = 6,
  parameter int DIV_HS_IOF = 3
) (
  input  logic          host_fast,
  input  logic          io_fast,
  output logic [CW-1:0] div_next
);
  io_rate_e rate;

  always_comb begin
    rate = rate_of(host_fast, io_fast);
    unique case (rate)
      RATE_HF_IOS: div_next = CW'(DIV_HF_IOS);
      RATE_HF_IOF: div_next = CW'(DIV_HF_IOF);
      RATE_HS_IOS: div_next = CW'(DIV_HS_IOS);
      default:     div_next = CW'(DIV_HS_IOF);
    endcase
  end
endmodule

// File: rtl/iodiv_period_ctr.sv
`timescale 1ns/1ps
module iodiv_period_ctr #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          gate_en,
  input  logic [CW-1:0] div_next,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] div_q,
  output logic          run,
  output logic          pos_ph,
  output logic          done
);
  logic          boundary;
  logic [CW-1:0] cnt_inc;
  logic [CW-1:0] high_len;

  // A period ends at its last count; a stopped divider sits at a boundary every cycle.
  assign boundary = !run || (cnt == div_q - CW'(1));
  assign cnt_inc  = cnt + CW'(1);
  // Whole input cycles of high phase; an odd count gets its extra half elsewhere.
  assign high_len = div_q >> 1;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      run    <= 1'b0;
      pos_ph <= 1'b0;
      done   <= 1'b0;
      div_q  <= div_next;
    end else if (boundary) begin
      cnt    <= '0;
      run    <= gate_en;
      pos_ph <= gate_en;
      div_q  <= div_next;
      done   <= (div_next != div_q);
    end else begin
      cnt    <= cnt_inc;
      pos_ph <= (cnt_inc < high_len);
      done   <= 1'b0;
    end
  end
endmodule

// File: rtl/iodiv_half_phase.sv
`timescale 1ns/1ps
module iodiv_half_phase #(
  parameter bit HAS_ODD = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic pos_ph,
  input  logic odd_en,
  output logic neg_ph
);
  generate
    if (HAS_ODD) begin : g_odd
      // Copies the rising-edge phase half a cycle late, which stretches the high phase by half a cycle.
      always_ff @(negedge clk) begin
        if (rst) neg_ph <= 1'b0;
        else     neg_ph <= pos_ph & odd_en;
      end
    end else begin : g_even
      assign neg_ph = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/iodiv_clkgen.sv
`timescale 1ns/1ps
module iodiv_clkgen
  import iodiv_pkg::*;
#(
  parameter int DIV_HF_IOS = 8,
  parameter int DIV_HF_IOF = 4,
  parameter int DIV_HS_IOS = 6,
  parameter int DIV_HS_IOF = 3
) (
  input  logic clk2x,
  input  logic rst,
  input  logic host_fast,
  input  logic io_fast,
  input  logic gate_en,
  output logic io_clk,
  output logic ratio_done
);
  localparam int MAXDIV  = max2(max2(DIV_HF_IOS, DIV_HF_IOF), max2(DIV_HS_IOS, DIV_HS_IOF));
  localparam int CW      = $clog2(MAXDIV + 1);
  localparam bit HAS_ODD = ((DIV_HF_IOS % 2) != 0) || ((DIV_HF_IOF % 2) != 0) ||
                           ((DIV_HS_IOS % 2) != 0) || ((DIV_HS_IOF % 2) != 0);

  logic [CW-1:0] div_next_w;
  logic [CW-1:0] cnt_w;
  logic [CW-1:0] div_q_w;
  logic          run_w;
  logic          pos_w;
  logic          neg_w;
  logic          done_w;

  iodiv_rate_sel #(
    .CW(CW), .DIV_HF_IOS(DIV_HF_IOS), .DIV_HF_IOF(DIV_HF_IOF),
    .DIV_HS_IOS(DIV_HS_IOS), .DIV_HS_IOF(DIV_HS_IOF)
  ) u_sel (
    .host_fast (host_fast),
    .io_fast   (io_fast),
    .div_next  (div_next_w)
  );

  iodiv_period_ctr #(.CW(CW)) u_ctr (
    .clk      (clk2x),
    .rst      (rst),
    .gate_en  (gate_en),
    .div_next (div_next_w),
    .cnt      (cnt_w),
    .div_q    (div_q_w),
    .run      (run_w),
    .pos_ph   (pos_w),
    .done     (done_w)
  );

  iodiv_half_phase #(.HAS_ODD(HAS_ODD)) u_half (
    .clk    (clk2x),
    .rst    (rst),
    .pos_ph (pos_w),
    .odd_en (div_q_w[0]),
    .neg_ph (neg_w)
  );

  assign io_clk     = pos_w | neg_w;
  assign ratio_done = done_w;
endmodule

// File: rtl/iodiv_clkgen_chk.sv
`timescale 1ns/1ps
module iodiv_clkgen_chk #(
  parameter int CW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          io_clk,
  input logic          ratio_done,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] div_q,
  input logic          run,
  input logic          pos_ph
);
  p_cnt_in_period_r1: assert property (@(posedge clk) disable iff (rst)
    cnt < div_q);

  p_rise_at_start_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(pos_ph) |-> (cnt == '0));

  p_ratio_at_boundary_r5: assert property (@(posedge clk) disable iff (rst)
    !$stable(div_q) |-> (cnt == '0));

  p_done_at_start_r6: assert property (@(posedge clk) disable iff (rst)
    ratio_done |-> (cnt == '0));

  p_stopped_low_r7: assert property (@(posedge clk) disable iff (rst)
    !run |-> !io_clk);
endmodule

bind iodiv_clkgen iodiv_clkgen_chk #(.CW(CW)) u_chk (
  .clk        (clk2x),
  .rst        (rst),
  .io_clk     (io_clk),
  .ratio_done (ratio_done),
  .cnt        (cnt_w),
  .div_q      (div_q_w),
  .run        (run_w),
  .pos_ph     (pos_w)
);

// File: tb/test_iodiv_clkgen.sv
`timescale 1ns/1ps
module test_iodiv_clkgen;
  logic clk2x = 1'b0;
  logic rst = 1'b1;
  logic host_fast = 1'b1;
  logic io_fast = 1'b0;
  logic gate_en = 1'b1;
  logic io_clk;
  logic ratio_done;

  int nchk = 0;
  int nfail = 0;

  bit wv [0:1023];
  bit dn [0:1023];
  int nw = 0;
  int rl [0:511];
  int rs [0:511];
  bit rv [0:511];
  int nr = 0;

  always #2.5 clk2x = ~clk2x;

  iodiv_clkgen i_iodiv_clkgen (
    .clk2x(clk2x), .rst(rst), .host_fast(host_fast), .io_fast(io_fast),
    .gate_en(gate_en), .io_clk(io_clk), .ratio_done(ratio_done)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clear();
    nw = 0;
  endtask

  // One sample 1.25 ns after every clock edge, rising or falling.
  task automatic capture(input int n);
    for (int i = 0; i < n; i++) begin
      @(clk2x);
      #1.25;
      if (nw < 1024) begin
        wv[nw] = io_clk;
        dn[nw] = ratio_done;
        nw++;
      end
    end
  endtask

  task automatic get_runs();
    nr = 0;
    for (int i = 0; i < nw; i++) begin
      if (i == 0 || wv[i] != wv[i-1]) begin
        rv[nr] = wv[i]; rs[nr] = i; rl[nr] = 1; nr++;
      end else begin
        rl[nr-1]++;
      end
    end
  endtask

  function automatic int done_count();
    int c = 0;
    for (int i = 0; i < nw; i++) if (dn[i]) c++;
    return c;
  endfunction

  // The phase length in half-cycle samples equals twice the host ratio.
  task automatic t_mode(input bit hf, input bit iof, input string req, input int p);
    int bad = 0;
    int highs = 0;
    host_fast = hf; io_fast = iof;
    capture(48);
    clear();
    capture(8*p + 4);
    get_runs();
    for (int r = 1; r < nr - 1; r++) begin
      if (rl[r] != p) bad++;
      if (rv[r]) highs++;
      chk(rl[r] == p, req, "phase length", rl[r], p);
    end
    chk(bad == 0 && highs >= 3, "R3", "unbalanced or missing phases", bad, 0);
    chk(done_count() == 0, "R6", "done pulse with steady selects", done_count(), 0);
  endtask

  task automatic t_rise_edge();
    int badr = 0;
    @(posedge clk2x); #1.25;
    clear();
    capture(40);
    // Even index = falling-edge sample, odd index = rising-edge sample.
    for (int i = 1; i < nw; i++) if (wv[i] && !wv[i-1] && (i % 2 == 0)) badr++;
    chk(badr == 0, "R4", "rise after a falling clock edge", badr, 0);
  endtask

  task automatic t_change(input bit hf1, input bit iof1, input int p0, input int p1, input int off);
    int ci, rc, fb, bad, ord, fd;
    clear();
    capture(4*p0 + off);
    ci = nw - 1;
    host_fast = hf1; io_fast = iof1;
    capture(4*p0 + 8*p1);
    get_runs();
    bad = 0; ord = 0; fb = -1; rc = -1; fd = -1;
    for (int r = 1; r < nr - 1; r++) begin
      if (rl[r] != p0 && rl[r] != p1) bad++;
      if (fb < 0 && rl[r] == p1) fb = r;
      else if (fb >= 0 && rl[r] != p1) ord++;
    end
    for (int r = 0; r < nr; r++) if (rs[r] <= ci && ci < rs[r] + rl[r]) rc = r;
    for (int i = nw - 1; i >= 0; i--) if (dn[i]) fd = i;
    chk(bad == 0, "R5", "phase of neither length", bad, 0);
    chk(rc >= 0 && rl[rc] == p0, "R5", "phase at select change cut", (rc >= 0) ? rl[rc] : -1, p0);
    chk(fb > 0 && ord == 0, "R5", "old length after new", ord, 0);
    chk(done_count() == 2, "R6", "done width in samples", done_count(), 2);
    chk(fb > 0 && rv[fb] && fd == rs[fb], "R6", "done start sample", fd, (fb > 0) ? rs[fb] : -1);
  endtask

  task automatic t_gate(input int p);
    int ci, rc, rises;
    clear();
    for (int k = 0; k < 200; k++) begin
      capture(1);
      if (nw > 1 && wv[nw-1] && !wv[nw-2]) break;
    end
    ci = nw - 1;
    gate_en = 1'b0;
    capture(6*p + 10);
    get_runs();
    rc = -1; rises = 0;
    for (int r = 0; r < nr; r++) if (rs[r] <= ci && ci < rs[r] + rl[r]) rc = r;
    for (int i = ci + 1; i < nw; i++) if (wv[i] && !wv[i-1]) rises++;
    chk(rc >= 0 && rv[rc] && rl[rc] == p, "R7", "high phase at gate drop", (rc >= 0) ? rl[rc] : -1, p);
    chk(rises == 0, "R7", "rise while gated", rises, 0);
    chk(wv[nw-1] == 1'b0, "R7", "output while gated", wv[nw-1], 0);
    @(posedge clk2x); #1.25;
    gate_en = 1'b1;
    clear();
    capture(2*p + 3);
    get_runs();
    chk(wv[0] == 1'b0 && wv[1] == 1'b1, "R8", "restart edge", {wv[0], wv[1]}, 1);
    chk(nr > 2 && rl[1] == p, "R8", "first high phase after restart", (nr > 1) ? rl[1] : -1, p);
  endtask

  task automatic t_reset_start();
    clear();
    capture(6);
    chk(wv[1] == 0 && wv[2] == 0 && wv[3] == 0 && wv[4] == 0 && wv[5] == 0, "R9", "io_clk in reset",
        wv[5], 0);
    chk(done_count() == 0, "R9", "done in reset", done_count(), 0);
    @(posedge clk2x); #1.25;
    rst = 1'b0;
    clear();
    capture(3);
    chk(wv[0] == 0 && wv[1] == 1, "R9", "first rise after release", {wv[0], wv[1]}, 1);
  endtask

  task automatic t_reset_mid();
    host_fast = 1'b0; io_fast = 1'b1;
    capture(40);
    @(posedge clk2x); #1.25;
    rst = 1'b1;
    host_fast = 1'b1; io_fast = 1'b0;
    clear();
    capture(6);
    chk(wv[1] == 0 && wv[2] == 0 && wv[3] == 0 && wv[5] == 0, "R9", "io_clk held low in reset", wv[2], 0);
    chk(done_count() == 0, "R9", "done during reset", done_count(), 0);
    @(posedge clk2x); #1.25;
    rst = 1'b0;
    clear();
    capture(2*8 + 4);
    get_runs();
    chk(wv[0] == 0 && wv[1] == 1 && nr > 2 && rl[1] == 8, "R9", "ratio after release",
        (nr > 1) ? rl[1] : -1, 8);
    chk(done_count() == 0, "R9", "done after release", done_count(), 0);
  endtask

  initial begin
    #(200000 * 5);
    nfail++;
    $display("FAIL watchdog: actual 0 expected 1 (run completed)");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    t_reset_start();
    t_mode(1'b1, 1'b0, "R1", 8);
    t_mode(1'b1, 1'b1, "R1", 4);
    t_mode(1'b0, 1'b0, "R2", 6);
    t_mode(1'b0, 1'b1, "R2", 3);
    t_rise_edge();
    t_change(1'b1, 1'b0, 3, 8, 1);
    t_change(1'b0, 1'b0, 8, 6, 5);
    t_change(1'b0, 1'b1, 6, 3, 2);
    t_change(1'b1, 1'b1, 3, 4, 4);
    t_change(1'b1, 1'b0, 4, 8, 3);
    t_gate(8);
    host_fast = 1'b0; io_fast = 1'b1;
    capture(48);
    t_gate(3);
    t_reset_mid();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule